// File: doc/BRIEF.md
# Ternary Sequent Rule Engine

This block is a synchronous logic controller whose whole behaviour is a list of cause/effect rules. Every rule has a cause term and an effect term. The cause term is a product over the input bits, the inner bits and the output bits. The effect term names the stored bits to force to 1 or to 0. The rules are fixed at build time as two ternary matrices. The cause matrix forms an AND plane, which produces one match line per rule. The effect matrix forms an OR plane, which collects a set line and a clear line for every stored bit.

The inner and output bits sit in set/clear flip-flops. All rules that match in a cycle act together at the next rising edge. A stored bit that no matching rule names keeps its value. A combinational flag reports when two matching rules drive the same bit to opposite values; in that case the bit holds. A second flag is a constant computed from the matrices. It states whether the rule set is consistent: any two rules whose effects disagree on some bit must have causes that can never both be true.

Top module: `sre_engine`

## Requirements
- R1: Each matrix entry is a 2-bit code: 00 = don't-care, 01 = must be 0, 10 = must be 1 (11 is treated as don't-care). Cause columns are numbered inputs first (bits 0..N_IN-1), then inner bits, then output bits. Rule r occupies row r, with column c at bits [2*(r*columns+c) +: 2]. A rule matches when every entry of its cause row that is not don't-care equals the current value of its variable.
- R2: Effect columns are inner bits first, then output bits. For a matching rule, a 10 entry sets the bit and a 01 entry clears it, at the next rising clock edge.
- R3: Several rules that match in the same cycle are all applied at the same edge, each to the bits it names.
- R4: A stored bit that no matching rule names keeps its present value.
- R5: `conflict_o` is high combinationally, in the same cycle, whenever some stored bit receives both a set and a clear from matching rules. That bit then keeps its old value, while the other bits still update.
- R6: While `rst_n` is low at a rising edge, the inner and output bits load the parameter INIT_STATE (inner bits in the low positions).
- R7: `consistent_o` is a constant. It is 1 exactly when every pair of rules whose effect rows disagree on some bit (one demands 1, the other 0) also has cause rows that disagree on some variable.
- R8: `inner_q` and `out_q` show the stored bits, and the cause plane reads these same stored bits back as variables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_bits | input | N_IN | External condition bits |
| inner_q | output | N_INNER | Stored inner bits |
| out_q | output | N_OUT | Stored output bits |
| conflict_o | output | 1 | Opposite demands on one bit this cycle |
| consistent_o | output | 1 | Static consistency verdict of the rule set |

## Verification
On every cycle, the assertions check the following against the set and clear lines for each bit: a lone set yields 1, a lone clear yields 0, and no demand or opposing demands leave the bit unchanged. They also check that a reset cycle loads the initial vector and that a consistent rule set never raises the conflict flag. The assertions cannot show that the AND plane decodes the ternary codes correctly, that concurrent rules combine as intended, or that the static verdict matches the matrices. The bench's scenario table shows these by comparing whole state trajectories against values worked out by hand. It also checks the verdict of a second, consistent rule set.

// File: rtl/sre_pkg.sv
// sre_pkg: shared ternary codes and helpers for the sequent rule engine.
// Assumes entries are packed as 2-bit codes in flat parameter vectors.
package sre_pkg;

    localparam logic [1:0] SC_DC   = 2'b00;
    localparam logic [1:0] SC_ZERO = 2'b01;
    localparam logic [1:0] SC_ONE  = 2'b10;

    // True when a ternary entry accepts the given variable value.
    function automatic logic code_accepts(input logic [1:0] code, input logic val);
        case (code)
            SC_ZERO: code_accepts = ~val;
            SC_ONE:  code_accepts = val;
            default: code_accepts = 1'b1;
        endcase
    endfunction

    // True when two entries demand opposite values of the same variable.
    function automatic logic codes_orthogonal(input logic [1:0] a, input logic [1:0] b);
        codes_orthogonal = ((a == SC_ONE) && (b == SC_ZERO)) ||
                           ((a == SC_ZERO) && (b == SC_ONE));
    endfunction

endpackage

// File: rtl/sre_cause_plane.sv
// sre_cause_plane: AND plane. One match line per rule, high when every
// specified entry of the rule's cause row equals its variable.
// Assumes CAUSE_MAT holds N_RULES rows of N_VAR 2-bit codes, row 0 lowest.
module sre_cause_plane #(
    parameter int N_VAR   = 7,
    parameter int N_RULES = 6,
    parameter logic [N_RULES*N_VAR*2-1:0] CAUSE_MAT = '0
) (
    input  logic [N_VAR-1:0]   vars_i,
    output logic [N_RULES-1:0] match_o
);

    import sre_pkg::*;

    for (genvar r = 0; r < N_RULES; r++) begin : g_row
        logic [N_VAR-1:0] term_ok;
        for (genvar c = 0; c < N_VAR; c++) begin : g_col
            localparam logic [1:0] CODE = CAUSE_MAT[2*(r*N_VAR+c) +: 2];
            // Literal check of one cause entry against its variable.
            always_comb term_ok[c] = code_accepts(CODE, vars_i[c]);
        end
        // Product of all literals of the row.
        always_comb match_o[r] = &term_ok;
    end

endmodule

// File: rtl/sre_effect_plane.sv
// sre_effect_plane: OR plane. Collects, per stored bit, the set function
// (rows with 1) and the clear function (rows with 0) over matching rules.
// Assumes EFFECT_MAT holds N_RULES rows of N_ST 2-bit codes, row 0 lowest.
module sre_effect_plane #(
    parameter int N_ST    = 4,
    parameter int N_RULES = 6,
    parameter logic [N_RULES*N_ST*2-1:0] EFFECT_MAT = '0
) (
    input  logic [N_RULES-1:0] match_i,
    output logic [N_ST-1:0]    set_o,
    output logic [N_ST-1:0]    clr_o
);

    import sre_pkg::*;

    for (genvar c = 0; c < N_ST; c++) begin : g_col
        logic [N_RULES-1:0] on_hit;
        logic [N_RULES-1:0] off_hit;
        for (genvar r = 0; r < N_RULES; r++) begin : g_row
            localparam logic [1:0] CODE = EFFECT_MAT[2*(r*N_ST+c) +: 2];
            // Route the match line into the ON or OFF sum of this column.
            always_comb begin
                on_hit[r]  = match_i[r] && (CODE == SC_ONE);
                off_hit[r] = match_i[r] && (CODE == SC_ZERO);
            end
        end
        // Sum terms of the column.
        always_comb begin
            set_o[c] = |on_hit;
            clr_o[c] = |off_hit;
        end
    end

endmodule

// File: rtl/sre_state_regs.sv
// sre_state_regs: set/clear flip-flops for inner and output bits.
// Lone set -> 1, lone clear -> 0, none or both -> hold.
// Assumes synchronous active-low reset loading INIT_STATE.
module sre_state_regs #(
    parameter int N_ST = 4,
    parameter logic [N_ST-1:0] INIT_STATE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_ST-1:0] set_i,
    input  logic [N_ST-1:0] clr_i,
    output logic [N_ST-1:0] state_o
);

    for (genvar j = 0; j < N_ST; j++) begin : g_bit
        // One set/clear cell with hold on no demand or opposing demands.
        always_ff @(posedge clk) begin
            if (!rst_n)
                state_o[j] <= INIT_STATE[j];
            else if (set_i[j] && !clr_i[j])
                state_o[j] <= 1'b1;
            else if (clr_i[j] && !set_i[j])
                state_o[j] <= 1'b0;
        end
    end

endmodule

// File: rtl/sre_engine.sv
// sre_engine: top of the ternary sequent rule engine. Wires the AND plane,
// OR plane and state flops, raises the runtime conflict flag and exposes a
// constant consistency verdict computed from the rule matrices.
// Assumes variable order inputs, inner, outputs; stored order inner, outputs.
module sre_engine #(
    parameter int N_IN    = 3,
    parameter int N_INNER = 2,
    parameter int N_OUT   = 2,
    parameter int N_RULES = 6,
    parameter logic [N_RULES*(N_IN+N_INNER+N_OUT)*2-1:0] CAUSE_MAT = {
        {sre_pkg::SC_ONE,  sre_pkg::SC_ONE,  sre_pkg::SC_DC,   sre_pkg::SC_DC,
         sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC},
        {sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_ONE,  sre_pkg::SC_ZERO,
         sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC},
        {sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_ONE,
         sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_ZERO},
        {sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC,
         sre_pkg::SC_ONE,  sre_pkg::SC_DC,   sre_pkg::SC_DC},
        {sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC,
         sre_pkg::SC_DC,   sre_pkg::SC_ONE,  sre_pkg::SC_DC},
        {sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_ZERO,
         sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_ONE}
    },
    parameter logic [N_RULES*(N_INNER+N_OUT)*2-1:0] EFFECT_MAT = {
        {sre_pkg::SC_ZERO, sre_pkg::SC_ZERO, sre_pkg::SC_DC,   sre_pkg::SC_DC},
        {sre_pkg::SC_ONE,  sre_pkg::SC_DC,   sre_pkg::SC_ZERO, sre_pkg::SC_DC},
        {sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_ONE,  sre_pkg::SC_ZERO},
        {sre_pkg::SC_DC,   sre_pkg::SC_ZERO, sre_pkg::SC_DC,   sre_pkg::SC_DC},
        {sre_pkg::SC_DC,   sre_pkg::SC_ONE,  sre_pkg::SC_DC,   sre_pkg::SC_DC},
        {sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_DC,   sre_pkg::SC_ONE}
    },
    parameter logic [N_INNER+N_OUT-1:0] INIT_STATE = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IN-1:0]    in_bits,
    output logic [N_INNER-1:0] inner_q,
    output logic [N_OUT-1:0]   out_q,
    output logic               conflict_o,
    output logic               consistent_o
);

    import sre_pkg::*;

    localparam int N_ST  = N_INNER + N_OUT;
    localparam int N_VAR = N_IN + N_ST;

    // Static check: rules with opposing effects must have exclusive causes.
    function automatic logic rules_consistent();
        for (int i = 0; i < N_RULES; i++) begin
            for (int j = i + 1; j < N_RULES; j++) begin
                logic eff_x;
                logic cau_x;
                eff_x = 1'b0;
                cau_x = 1'b0;
                for (int k = 0; k < N_ST; k++)
                    if (codes_orthogonal(EFFECT_MAT[2*(i*N_ST+k) +: 2],
                                         EFFECT_MAT[2*(j*N_ST+k) +: 2]))
                        eff_x = 1'b1;
                for (int k = 0; k < N_VAR; k++)
                    if (codes_orthogonal(CAUSE_MAT[2*(i*N_VAR+k) +: 2],
                                         CAUSE_MAT[2*(j*N_VAR+k) +: 2]))
                        cau_x = 1'b1;
                if (eff_x && !cau_x)
                    return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    localparam logic RULES_OK = rules_consistent();

    logic [N_ST-1:0]    st_q;
    logic [N_VAR-1:0]   vars_w;
    logic [N_RULES-1:0] match_w;
    logic [N_ST-1:0]    set_v;
    logic [N_ST-1:0]    clr_v;

    // Assemble the variable vector: inputs low, then stored bits.
    always_comb vars_w = {st_q, in_bits};

    sre_cause_plane #(
        .N_VAR     (N_VAR),
        .N_RULES   (N_RULES),
        .CAUSE_MAT (CAUSE_MAT)
    ) and_plane_i (
        .vars_i  (vars_w),
        .match_o (match_w)
    );

    sre_effect_plane #(
        .N_ST       (N_ST),
        .N_RULES    (N_RULES),
        .EFFECT_MAT (EFFECT_MAT)
    ) or_plane_i (
        .match_i (match_w),
        .set_o   (set_v),
        .clr_o   (clr_v)
    );

    sre_state_regs #(
        .N_ST       (N_ST),
        .INIT_STATE (INIT_STATE)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .state_o (st_q)
    );

    // Drive the output ports and the two flags.
    always_comb begin
        inner_q      = st_q[N_INNER-1:0];
        out_q        = st_q[N_ST-1:N_INNER];
        conflict_o   = |(set_v & clr_v);
        consistent_o = RULES_OK;
    end

endmodule

// File: rtl/sre_engine_chk.sv
// sre_engine_chk: property checker bound into sre_engine. Relates the OR
// plane's set/clear lines to the next stored value and checks reset/flags.
module sre_engine_chk #(
    parameter int N_ST = 4,
    parameter logic [N_ST-1:0] INIT_STATE = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_ST-1:0] st_q,
    input logic [N_ST-1:0] set_v,
    input logic [N_ST-1:0] clr_v,
    input logic            conflict_o,
    input logic            consistent_o
);

    // R6
    reset_load_chk: assert property (@(posedge clk) !rst_n |=> (st_q == INIT_STATE));

    // R7
    consistent_no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consistent_o |-> !conflict_o);

    // R4
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!conflict_o && ((set_v | clr_v) == '0)) |=> $stable(st_q));

    for (genvar j = 0; j < N_ST; j++) begin : g_bit
        // R2
        set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[j] && !clr_v[j]) |=> st_q[j]);
        // R2
        clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[j] && !set_v[j]) |=> !st_q[j]);
        // R5
        clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[j] && clr_v[j]) |=> $stable(st_q[j]));
        // R4
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_v[j] && !clr_v[j]) |=> $stable(st_q[j]));
    end

endmodule

bind sre_engine sre_engine_chk #(
    .N_ST       (N_ST),
    .INIT_STATE (INIT_STATE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_q         (st_q),
    .set_v        (set_v),
    .clr_v        (clr_v),
    .conflict_o   (conflict_o),
    .consistent_o (consistent_o)
);

// File: tb/sre_engine_tb_top.sv
// Bench for sre_engine. Default rules (variables a,b,c = in_bits[0..2],
// p,q = inner_q[0..1], u,v = out_q[0..1]):
//   r0 a&!p -> p=1   r1 b -> u=1   r2 c -> u=0
//   r3 p&!a -> q=1,p=0   r4 q&!p -> v=1,q=0   r5 u&v -> u=0,v=0
// State is shown as {v,u,q,p}; INIT_STATE = 0100.
module sre_engine_tb_top;

    import sre_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] in_bits = 3'b000;
    logic [1:0] inner_q, out_q, inner2_q, out2_q;
    logic       conflict_o, consistent_o, conflict2_o, consistent2_o;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    sre_engine dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_bits      (in_bits),
        .inner_q      (inner_q),
        .out_q        (out_q),
        .conflict_o   (conflict_o),
        .consistent_o (consistent_o)
    );

    // Consistent subset: rules r0, r3, r4 only.
    sre_engine #(
        .N_RULES   (3),
        .CAUSE_MAT ({
            {SC_DC, SC_DC, SC_ONE, SC_ZERO, SC_DC, SC_DC, SC_DC},
            {SC_DC, SC_DC, SC_DC,  SC_ONE,  SC_DC, SC_DC, SC_ZERO},
            {SC_DC, SC_DC, SC_DC,  SC_ZERO, SC_DC, SC_DC, SC_ONE}}),
        .EFFECT_MAT ({
            {SC_ONE, SC_DC, SC_ZERO, SC_DC},
            {SC_DC,  SC_DC, SC_ONE,  SC_ZERO},
            {SC_DC,  SC_DC, SC_DC,   SC_ONE}})
    ) dut_c_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_bits      (in_bits),
        .inner_q      (inner2_q),
        .out_q        (out2_q),
        .conflict_o   (conflict2_o),
        .consistent_o (consistent2_o)
    );

    // Vector: {in c,b,a [7:5], expected state after edge [4:1], expected conflict [0]}
    localparam logic [7:0] VEC [12] = '{
        {3'b001, 4'b0101, 1'b0},   // R1 R2: r0 sets p
        {3'b000, 4'b0110, 1'b0},   // R2 R8: r3 q=1 p=0 via feedback
        {3'b000, 4'b1100, 1'b0},   // R2: r4 v=1 q=0
        {3'b000, 4'b0000, 1'b0},   // R2: r5 clears u,v
        {3'b110, 4'b0000, 1'b1},   // R5: b&c clash on u, u holds 0
        {3'b010, 4'b0100, 1'b0},   // R2: r1 sets u
        {3'b100, 4'b0000, 1'b0},   // R2: r2 clears u
        {3'b011, 4'b0101, 1'b0},   // R3: r0 and r1 together
        {3'b001, 4'b0101, 1'b0},   // R4: no rule matches, all hold
        {3'b110, 4'b0110, 1'b1},   // R5 R3: u holds 1 while r3 updates p,q
        {3'b000, 4'b1100, 1'b0},   // R2: r4
        {3'b000, 4'b0000, 1'b0}    // R2: r5
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] st4();
        return {4'b0000, out_q, inner_q};
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1600000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Stimulus and checks.
    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R6 reset state", st4(), 8'b0100);
        check("R7 inconsistent set", {7'd0, consistent_o}, 8'd0);
        check("R7 consistent set", {7'd0, consistent2_o}, 8'd1);
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            in_bits = VEC[i][7:5];
            #1;
            check($sformatf("R5 conflict step %0d", i), {7'd0, conflict_o}, {7'd0, VEC[i][0]});
            @(posedge clk);
            #1;
            check($sformatf("R2/R3/R4 state step %0d", i), st4(), {4'd0, VEC[i][4:1]});
            @(negedge clk);
        end

        // R6: reset in mid-run reloads the initial vector.
        in_bits = 3'b011;
        @(posedge clk);
        #1;
        check("R3 pre-reset state", st4(), 8'b0101);
        @(negedge clk);
        rst_n = 1'b0;
        in_bits = 3'b000;
        @(posedge clk);
        #1;
        check("R6 mid-run reset", st4(), 8'b0100);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule